// File: doc/BRIEF.md
# Shared DRAM Slot Arbiter for Processor and Display Scan

This block lets one multiplexed-address DRAM serve both a slow processor and a display scan engine without either side ever waiting. Every processor clock period is divided into two equal halves, and each half holds one full row-access cycle. The first half always belongs to the processor's memory operation. The second half always belongs to a display fetch.

Each half lasts four fast clock ticks. In the first tick the row strobe is high, which precharges the array. In the second tick the row strobe goes low. In the third tick the column half of the address is presented. In the fourth tick the column strobe is low and the data are valid. Read data are captured on the clock edge that closes the half.

The block has no refresh counter. The display address is split so that its low half selects the DRAM row. Because the scan engine advances the address once per processor period, every row is opened again after 2^ROW_W periods. This keeps the whole array refreshed while the display runs.

Top module: `dram_video_arb`

## Requirements
- R1: After reset, one processor period lasts 8 clock ticks, made of two 4-tick slots. Within each slot, the row strobe `dram_ras_n` is high in tick 0 and low in ticks 1..3. The column strobe `dram_cas_n` is low only in tick 3.
- R2: Ticks 0..3 of a period form the processor slot and ticks 4..7 form the display slot. `cpu_slot` is 1 exactly during the processor slot. The display slot never carries a processor access.
- R3: In the processor slot, `dram_addr` carries `cpu_addr[ROW_W-1:0]` (the row half) in ticks 0..1. It carries `cpu_addr[2*ROW_W-1:ROW_W]` (the column half) in ticks 2..3.
- R4: In the display slot, `dram_addr` carries `scan_addr[ROW_W-1:0]` as the row in ticks 4..5. It carries `scan_addr[2*ROW_W-1:ROW_W]` as the column in ticks 6..7.
- R5: `dram_we_n` is low and `dram_dq_oe` is high only in ticks 2..3 of a processor slot with `cpu_req`=1 and `cpu_we`=1. While `dram_dq_oe` is high, `dram_dq_o` equals `cpu_wdata`. The display slot is always a read.
- R6: At the edge that ends tick 3, `cpu_rdata` takes `dram_dq_i` if `cpu_req`=1 and `cpu_we`=0. At every other time, and after writes or idle periods, `cpu_rdata` holds its value.
- R7: At the edge that ends tick 7 of every period, `vid_data` takes `dram_dq_i`.
- R8: While `scan_addr` steps by one each period, every row is opened (row strobe falling with that row on `dram_addr`) at least once within every window of 8*2^ROW_W ticks. No extra refresh strobe is ever issued.
- R9: While `rst_n` is low, both strobes and `dram_we_n` are high, `dram_dq_oe` is low, and `cpu_rdata` and `vid_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four ticks per slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor has a memory operation this period |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2*ROW_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_rdata | output | DATA_W | Processor read data, captured at end of processor slot |
| cpu_slot | output | 1 | High during the processor slot (processor clock phase) |
| scan_addr | input | 2*ROW_W | Display scan counter |
| vid_data | output | DATA_W | Display fetch data, captured at end of display slot |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_dq_o | output | DATA_W | Data toward DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_o |
| dram_dq_i | input | DATA_W | Data from DRAM |

## Verification
The bench uses ROW_W=4 and DATA_W=8. This gives a 256-word array and 16 rows, so the whole refresh cycle repeats every 128 ticks. Several thousand ticks therefore cover dozens of complete row sweeps and every wrap of the 8-bit scan counter. The small array also lets a behavioural DRAM model hold all of its contents. Reads that follow writes to the same and to distant addresses can then be checked against an independent intent model.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

  // Position of a tick within a four-tick slot.
  typedef enum logic [1:0] {
    PH_PRE = 2'd0,  // row strobe high, precharge
    PH_ROW = 2'd1,  // row strobe low, row address held
    PH_COL = 2'd2,  // column address presented
    PH_XFR = 2'd3   // column strobe low, data valid
  } phase_t;

  localparam int unsigned TICKS_PER_SLOT = 4;
  localparam int unsigned SLOTS_PER_PERIOD = 2;

  function automatic logic row_strobe_on(phase_t p);
    return p != PH_PRE;
  endfunction

  function automatic logic col_strobe_on(phase_t p);
    return p == PH_XFR;
  endfunction

  function automatic logic column_half(phase_t p);
    return (p == PH_COL) || (p == PH_XFR);
  endfunction

endpackage

// File: rtl/dram_slot_seq.sv
module dram_slot_seq
  import dram_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output logic   vid_slot,
  output logic   slot_end
);
  localparam int unsigned TICK_W = $clog2(TICKS_PER_SLOT * SLOTS_PER_PERIOD);

  logic [TICK_W-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_q + 1'b1;
  end

  assign phase    = phase_t'(tick_q[1:0]);
  assign vid_slot = tick_q[TICK_W-1];
  assign slot_end = (phase == PH_XFR);

  AST_SLOT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slot_end) |-> (vid_slot != $past(vid_slot))); // R2
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_arb_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  phase_t              phase,
  input  logic                vid_slot,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [2*ROW_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [2*ROW_W-1:0]  scan_addr,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic [ROW_W-1:0]    addr,
  output logic [DATA_W-1:0]   dq_o,
  output logic                dq_oe
);
  localparam int unsigned AW = 2 * ROW_W;

  function automatic logic [ROW_W-1:0] row_part(logic [AW-1:0] a);
    return a[ROW_W-1:0];
  endfunction

  function automatic logic [ROW_W-1:0] col_part(logic [AW-1:0] a);
    return a[AW-1:ROW_W];
  endfunction

  logic [AW-1:0] src_addr;
  logic          cpu_write_now;

  assign src_addr      = vid_slot ? scan_addr : cpu_addr;
  assign cpu_write_now = !vid_slot && cpu_req && cpu_we && column_half(phase);

  always_comb begin
    ras_n = !row_strobe_on(phase);
    cas_n = !col_strobe_on(phase);
    addr  = column_half(phase) ? col_part(src_addr) : row_part(src_addr);
    we_n  = !cpu_write_now;
    dq_oe = cpu_write_now;
    dq_o  = cpu_wdata;
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge phase[0])
    !cas_n |-> !ras_n); // R1
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_end,
  input  logic              vid_slot,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] vid_data,
  output logic              cpu_cap_ev,
  output logic              vid_cap_ev
);
  assign cpu_cap_ev = slot_end && !vid_slot && cpu_req && !cpu_we;
  assign vid_cap_ev = slot_end && vid_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      vid_data  <= '0;
    end else begin
      if (cpu_cap_ev) cpu_rdata <= dq_i;
      if (vid_cap_ev) vid_data  <= dq_i;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cpu_cap_ev) |-> $stable(cpu_rdata)); // R6
  AST_VDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(vid_cap_ev) |-> $stable(vid_data)); // R7
endmodule

// File: rtl/dram_video_arb.sv
module dram_video_arb
  import dram_arb_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [2*ROW_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_slot,
  input  logic [2*ROW_W-1:0]  scan_addr,
  output logic [DATA_W-1:0]   vid_data,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic [ROW_W-1:0]    dram_addr,
  output logic [DATA_W-1:0]   dram_dq_o,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_i
);
  phase_t phase;
  logic   vid_slot;
  logic   slot_end;
  logic   cpu_cap_ev;
  logic   vid_cap_ev;

  dram_slot_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .vid_slot (vid_slot),
    .slot_end (slot_end)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_mux (
    .phase     (phase),
    .vid_slot  (vid_slot),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .scan_addr (scan_addr),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .addr      (dram_addr),
    .dq_o      (dram_dq_o),
    .dq_oe     (dram_dq_oe)
  );

  dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_end   (slot_end),
    .vid_slot   (vid_slot),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .dq_i       (dram_dq_i),
    .cpu_rdata  (cpu_rdata),
    .vid_data   (vid_data),
    .cpu_cap_ev (cpu_cap_ev),
    .vid_cap_ev (vid_cap_ev)
  );

  assign cpu_slot = !vid_slot;

  AST_WE_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> cpu_slot); // R5
  AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_cap_ev, vid_cap_ev})); // R2
  AST_VCAP_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    vid_cap_ev |-> !dram_cas_n); // R7
  AST_CCAP_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cap_ev |-> (dram_we_n && !dram_cas_n)); // R6
endmodule

// File: tb/tb_dram_video_arb.sv
module tb_dram_video_arb;
  localparam int ROW_W  = 4;
  localparam int DATA_W = 8;
  localparam int AW     = 2 * ROW_W;
  localparam int NW     = 1 << AW;
  localparam int NROWS  = 1 << ROW_W;
  localparam int WIN    = 8 * NROWS;

  logic clk = 0;
  logic rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0, scan_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata, vid_data, dram_dq_o, dram_dq_i;
  logic cpu_slot, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
  logic [ROW_W-1:0] dram_addr;

  always #10 clk = ~clk;

  dram_video_arb #(.ROW_W(ROW_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_slot(cpu_slot), .scan_addr(scan_addr), .vid_data(vid_data),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i)
  );

  int n_chk = 0, n_bad = 0;
  int t = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at tick %0d: actual %0h expected %0h", req, t, act, exp);
    end
  endtask

  // Behavioural DRAM driven by the design's strobes
  logic [DATA_W-1:0] dmem [NW];
  logic [DATA_W-1:0] ref_mem [NW];
  logic [ROW_W-1:0] row_q = '0;
  logic prev_ras = 1'b1;
  int last_open [NROWS];
  assign dram_dq_i = dmem[{dram_addr, row_q}];

  logic [DATA_W-1:0] exp_cpu = '0, exp_vid = '0;

  initial begin
    for (int i = 0; i < NW; i++) begin
      dmem[i] = DATA_W'(i * 37 + 5);
      ref_mem[i] = DATA_W'(i * 37 + 5);
    end
    for (int r = 0; r < NROWS; r++) last_open[r] = 0;
  end

  // Intent model, advanced on every active edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (t % 8 == 3 && cpu_req) begin
        if (cpu_we) ref_mem[cpu_addr] = cpu_wdata;
        else exp_cpu <= ref_mem[cpu_addr];
      end
      if (t % 8 == 7) exp_vid <= ref_mem[scan_addr];
      t <= t + 1;
    end
  end

  // Per-tick comparison and DRAM model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int ph; bit vs, wr; logic [AW-1:0] src; logic [ROW_W-1:0] ea;
      ph = t % 4;
      vs = (t % 8) >= 4;
      wr = !vs && cpu_req && cpu_we && ph >= 2;
      src = vs ? scan_addr : cpu_addr;
      ea = (ph < 2) ? src[ROW_W-1:0] : src[AW-1:ROW_W];
      chk("R1 ras_n", dram_ras_n, ph == 0);
      chk("R1 cas_n", dram_cas_n, ph != 3);
      chk("R2 cpu_slot", cpu_slot, !vs);
      chk(vs ? "R4 addr" : "R3 addr", dram_addr, ea);
      chk("R5 we_n", dram_we_n, !wr);
      chk("R5 dq_oe", dram_dq_oe, wr);
      if (wr) chk("R5 dq_o", dram_dq_o, cpu_wdata);
      chk("R6 cpu_rdata", cpu_rdata, exp_cpu);
      chk("R7 vid_data", vid_data, exp_vid);
      // DRAM model
      if (prev_ras && !dram_ras_n) begin
        row_q = dram_addr;
        last_open[dram_addr] = t;
      end
      if (!dram_cas_n && !dram_we_n) dmem[{dram_addr, row_q}] = dram_dq_o;
      prev_ras = dram_ras_n;
      // R8: every row opened within the refresh window
      if (t > WIN && ph == 0)
        for (int r = 0; r < NROWS; r++)
          chk("R8 row age ok", (t - last_open[r]) <= WIN, 1);
    end
  end

  task automatic period_op(bit req, bit we, int a, int d);
    do @(negedge clk); while (t % 8 != 7);
    #2;
    cpu_req = req; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = DATA_W'(d);
  endtask

  // Scan engine: one step per period, changed during the processor slot
  always @(negedge clk) begin
    if (rst_n && t % 8 == 3) begin
      #2 scan_addr <= scan_addr + 1'b1;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ras_n", dram_ras_n, 1);
    chk("R9 cas_n", dram_cas_n, 1);
    chk("R9 we_n", dram_we_n, 1);
    chk("R9 dq_oe", dram_dq_oe, 0);
    chk("R9 cpu_rdata", cpu_rdata, 0);
    chk("R9 vid_data", vid_data, 0);
    rst_n = 1;
    // R6 initial reads of preloaded data
    period_op(1, 0, 8'h00, 0);
    period_op(1, 0, 8'hA5, 0);
    // R5 writes then reads back, same row and different rows
    period_op(1, 1, 8'h12, 8'h3C);
    period_op(1, 1, 8'h22, 8'hC3);
    period_op(1, 0, 8'h12, 0);
    period_op(1, 0, 8'h22, 0);
    // R6 idle periods and writes keep read data
    period_op(0, 0, 8'h40, 0);
    period_op(1, 1, 8'hFF, 8'h81);
    period_op(0, 1, 8'h55, 8'h77);
    period_op(1, 0, 8'hFF, 0);
    period_op(1, 0, 8'h55, 0);
    // long mixed run: scan wraps several times (R4, R7, R8)
    for (int k = 0; k < 700; k++) begin
      int a;
      a = (k * 29 + 3) % NW;
      period_op(k % 5 != 4, k % 3 == 0, a, k * 11 + 1);
    end
    period_op(0, 0, 0, 0);
    repeat (16) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    finished = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule